// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block resolves a virtual-to-physical translation in hardware when the instruction-side or data-side TLB misses. It captures the missing virtual page number, which side missed, and whether the access is a fetch, a load or a store. It then reads one or two page table entries through a simple request/grant/response memory port. It either hands a finished translation to the TLB that missed, or it tells that side that the access faults.

Only one walk runs at a time. While the walker is away from its idle state it raises `active_o`. The surrounding core uses this signal to freeze the pipeline and to steer the shared memory port to the walker. Updating accessed/dirty bits and delivering traps are left to other logic. The bench sets the A and D bits in its own table entries.

Top module: `sv32_walker`

## Requirements
- R1: After reset the walker is idle. `active_o`, `mem_req_o` and all four fill/fault strobes are low.
- R2: A walk starts only when `paging_en_i` is high and at least one miss input is high. With paging disabled, a held miss leaves `active_o` and `mem_req_o` low.
- R3: The first read targets `{root_ppn_i, va[31:22], 2'b00}`, which is the root PPN times 4096 plus VPN[1] times 4.
- R4: After a pointer entry, the second read targets `{pointer.ppn, va[21:12], 2'b00}`.
- R5: An entry with V (bit 0) clear, or with W (bit 2) set while R (bit 1) is clear, ends the walk in a fault. This applies at either level.
- R6: A leaf at level 1 is a 4 MiB superpage. If its low PPN field (bits 19:10) is non-zero, the walk faults.
- R7: An entry at level 0 that is not a leaf faults. An entry is a leaf when R (bit 1) or X (bit 3) is set.
- R8: A fetch needs X, a load needs R and a store needs W. If the needed bit is missing, the walker faults one cycle after the leaf cycle.
- R9: For a superpage, `fill_ppn_o` is the entry's PPN[21:10] followed by VA[21:12], and `fill_super_o` is 1. For a 4 KiB page, `fill_ppn_o` is the level-0 entry's PPN and `fill_super_o` is 0. `fill_vpn_o` is VA[31:12].
- R10: A result is a one-cycle pulse on exactly one of `ifill_o`, `dfill_o`, `ifault_o` or `dfault_o`. The pulse goes to the side that started the walk, and the walker is idle in the next cycle.
- R11: `active_o` is high from the cycle after the walk starts through the result cycle. With zero-wait memory, results appear 3 cycles after the start for a level-1 outcome and 5 cycles after for a level-0 outcome. A permission fault adds 1 cycle.
- R12: When both sides miss in the same cycle, the data side is walked first. The instruction-side miss is walked after the walker returns to idle.
- R13: `mem_req_o` and `mem_addr_o` stay stable until `mem_gnt_i` is seen. There is never more than one read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| paging_en_i | input | 1 | Sv32 translation enabled |
| root_ppn_i | input | 22 | PPN of the root page table |
| imiss_i | input | 1 | Instruction TLB miss |
| iva_i | input | 32 | Instruction-side virtual address |
| dmiss_i | input | 1 | Data TLB miss |
| dva_i | input | 32 | Data-side virtual address |
| dstore_i | input | 1 | Data access is a store (else load) |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 34 | Physical address of the entry |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page table entry read |
| active_o | output | 1 | Walker busy: stall and port steering |
| ifill_o | output | 1 | Instruction TLB fill strobe |
| dfill_o | output | 1 | Data TLB fill strobe |
| ifault_o | output | 1 | Instruction-side page fault |
| dfault_o | output | 1 | Data-side page fault |
| fill_vpn_o | output | 20 | Virtual page number of the fill |
| fill_ppn_o | output | 22 | Translated physical page number |
| fill_super_o | output | 1 | Fill is a 4 MiB superpage |

## Verification
A wrong state in the walker shows up at the ports within one or two cycles. It can appear as a request with the wrong address, a second request before the first response, a result pulse on the wrong side, or an `active_o` that stays high after a result. Each table case therefore checks the latency of the walk, the side and kind of result, the PPN and VPN values, and whether the walker is idle in the next cycle. Directed cases also check the address of each request as it is issued, that a request is held while grant is withheld, and the order in which two misses in the same cycle are served.

// File: rtl/sv32w_pkg.sv
package sv32w_pkg;
  localparam int VA_W   = 32;
  localparam int VPN_W  = 10;
  localparam int PPN_W  = 22;
  localparam int OFF_W  = 12;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int PTE_W  = 32;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int PPN_LSB = 10;

  typedef enum logic [1:0] {ACC_FETCH, ACC_LOAD, ACC_STORE} acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L0_REQ, ST_L0_WAIT, ST_LEAF, ST_FAULT
  } walk_st_e;

  function automatic logic perm_ok(acc_e acc, logic r, logic w, logic x);
    case (acc)
      ACC_FETCH: return x;
      ACC_LOAD:  return r;
      default:   return w;
    endcase
  endfunction
endpackage

// File: rtl/sv32w_arb.sv
module sv32w_arb
  import sv32w_pkg::*;
(
  input  logic            en_i,
  input  logic            imiss_i,
  input  logic [VA_W-1:0] iva_i,
  input  logic            dmiss_i,
  input  logic [VA_W-1:0] dva_i,
  input  logic            dstore_i,
  output logic            start_o,
  output logic            side_d_o,
  output acc_e            acc_o,
  output logic [2*VPN_W-1:0] vpn_o
);
  logic unused_off;
  assign unused_off = ^{iva_i[OFF_W-1:0], dva_i[OFF_W-1:0]};

  // data side wins a tie; instruction miss stays pending
  assign start_o  = en_i & (imiss_i | dmiss_i);
  assign side_d_o = dmiss_i;
  assign acc_o    = dmiss_i ? (dstore_i ? ACC_STORE : ACC_LOAD) : ACC_FETCH;
  assign vpn_o    = dmiss_i ? dva_i[VA_W-1:OFF_W] : iva_i[VA_W-1:OFF_W];
endmodule

// File: rtl/sv32w_pte_eval.sv
module sv32w_pte_eval
  import sv32w_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  output logic             bad_o,
  output logic             leaf_o,
  output logic             misalign_o
);
  logic unused_bits;
  assign unused_bits = ^pte_i[PPN_LSB-1:4];

  assign bad_o      = ~pte_i[B_V] | (~pte_i[B_R] & pte_i[B_W]);
  assign leaf_o     = pte_i[B_R] | pte_i[B_X];
  assign misalign_o = |pte_i[PPN_LSB+VPN_W-1:PPN_LSB];
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32w_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               paging_en_i,
  input  logic [PPN_W-1:0]   root_ppn_i,
  input  logic               imiss_i,
  input  logic [VA_W-1:0]    iva_i,
  input  logic               dmiss_i,
  input  logic [VA_W-1:0]    dva_i,
  input  logic               dstore_i,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [PTE_W-1:0]   mem_rdata_i,
  output logic               active_o,
  output logic               ifill_o,
  output logic               dfill_o,
  output logic               ifault_o,
  output logic               dfault_o,
  output logic [2*VPN_W-1:0] fill_vpn_o,
  output logic [PPN_W-1:0]   fill_ppn_o,
  output logic               fill_super_o
);
  localparam int VPNF_W = 2 * VPN_W;

  walk_st_e st_q, st_d;
  logic start, side_d_w, side_d_q, super_q;
  acc_e acc_w, acc_q;
  logic [VPNF_W-1:0] vpn_w, vpn_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [2:0]        rwx_q;
  logic pte_bad, pte_leaf, pte_misal, leaf_ok, fill, fault;

  sv32w_arb u_arb (
    .en_i(paging_en_i), .imiss_i(imiss_i), .iva_i(iva_i),
    .dmiss_i(dmiss_i), .dva_i(dva_i), .dstore_i(dstore_i),
    .start_o(start), .side_d_o(side_d_w), .acc_o(acc_w), .vpn_o(vpn_w)
  );

  sv32w_pte_eval u_eval (
    .pte_i(mem_rdata_i), .bad_o(pte_bad), .leaf_o(pte_leaf), .misalign_o(pte_misal)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (start) st_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_gnt_i) st_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid_i) begin
        if (pte_bad)       st_d = ST_FAULT;
        else if (pte_leaf) st_d = pte_misal ? ST_FAULT : ST_LEAF;
        else               st_d = ST_L0_REQ;
      end
      ST_L0_REQ:  if (mem_gnt_i) st_d = ST_L0_WAIT;
      ST_L0_WAIT: if (mem_rvalid_i) st_d = (pte_bad || !pte_leaf) ? ST_FAULT : ST_LEAF;
      ST_LEAF:    st_d = leaf_ok ? ST_IDLE : ST_FAULT;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      side_d_q <= 1'b0;
      acc_q    <= ACC_FETCH;
      vpn_q    <= '0;
      ppn_q    <= '0;
      rwx_q    <= '0;
      super_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        side_d_q <= side_d_w;
        acc_q    <= acc_w;
        vpn_q    <= vpn_w;
        super_q  <= 1'b0;
      end
      if ((st_q == ST_L1_WAIT || st_q == ST_L0_WAIT) && mem_rvalid_i) begin
        ppn_q   <= mem_rdata_i[PTE_W-1:PPN_LSB];
        rwx_q   <= {mem_rdata_i[B_X], mem_rdata_i[B_W], mem_rdata_i[B_R]};
        super_q <= (st_q == ST_L1_WAIT);
      end
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = '0;
    if (st_q == ST_L1_REQ) begin
      mem_req_o  = 1'b1;
      mem_addr_o = {root_ppn_i, vpn_q[VPNF_W-1:VPN_W], 2'b00};
    end else if (st_q == ST_L0_REQ) begin
      mem_req_o  = 1'b1;
      mem_addr_o = {ppn_q, vpn_q[VPN_W-1:0], 2'b00};
    end
  end

  assign leaf_ok      = perm_ok(acc_q, rwx_q[0], rwx_q[1], rwx_q[2]);
  assign fill         = (st_q == ST_LEAF) && leaf_ok;
  assign fault        = (st_q == ST_FAULT);
  assign active_o     = (st_q != ST_IDLE);
  assign ifill_o      = fill & ~side_d_q;
  assign dfill_o      = fill & side_d_q;
  assign ifault_o     = fault & ~side_d_q;
  assign dfault_o     = fault & side_d_q;
  assign fill_vpn_o   = vpn_q;
  assign fill_super_o = super_q;
  assign fill_ppn_o   = super_q ? {ppn_q[PPN_W-1:VPN_W], vpn_q[VPN_W-1:0]} : ppn_q;

  a_r13_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r13_one_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);

  a_r10_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ifill_o, dfill_o, ifault_o, dfault_o}));

  a_r10_idle_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifill_o || dfill_o || ifault_o || dfault_o) |=> !active_o);

  a_r2_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !paging_en_i) |=> !active_o);

  a_r9_super_ppn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ifill_o || dfill_o) && fill_super_o) |-> (fill_ppn_o[VPN_W-1:0] == fill_vpn_o[VPN_W-1:0]));
endmodule

// File: tb/sim_sv32_walker.sv
module sim_sv32_walker;
  import sv32w_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic paging_en = 1'b0;
  logic [21:0] root_ppn = 22'h5;
  logic imiss = 1'b0, dmiss = 1'b0, dstore = 1'b0;
  logic [31:0] iva = '0, dva = '0;
  logic mem_req, mem_gnt, mem_rvalid;
  logic [33:0] mem_addr;
  logic [31:0] mem_rdata;
  logic gnt_en = 1'b1;
  logic active, ifill, dfill, ifault, dfault, fsuper;
  logic [19:0] fvpn;
  logic [21:0] fppn;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] pmem [logic [33:0]];

  always #4 clk = ~clk;

  sv32_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .paging_en_i(paging_en), .root_ppn_i(root_ppn),
    .imiss_i(imiss), .iva_i(iva), .dmiss_i(dmiss), .dva_i(dva), .dstore_i(dstore),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .active_o(active),
    .ifill_o(ifill), .dfill_o(dfill), .ifault_o(ifault), .dfault_o(dfault),
    .fill_vpn_o(fvpn), .fill_ppn_o(fppn), .fill_super_o(fsuper)
  );

  function automatic logic [31:0] rd(logic [33:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  assign mem_gnt = mem_req & gnt_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req & gnt_en;
      mem_rdata  <= rd(mem_addr);
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 ifill 1 dfill 2 ifault 3 dfault
  typedef struct packed {
    logic        d;
    logic        st;
    logic [31:0] va;
    logic [1:0]  kind;
    logic [21:0] ppn;
    logic        sup;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 1'b0, 32'h00001ABC, 2'd1, 22'h123,  1'b0, 4'd5}, // R4 R9 load 4K
    '{1'b1, 1'b1, 32'h00001ABC, 2'd1, 22'h123,  1'b0, 4'd5}, // R8 store 4K
    '{1'b0, 1'b0, 32'h00001000, 2'd2, 22'h0,    1'b0, 4'd6}, // R8 fetch no X
    '{1'b0, 1'b0, 32'h00002000, 2'd0, 22'h77,   1'b0, 4'd5}, // R8 fetch X only
    '{1'b1, 1'b0, 32'h00002000, 2'd3, 22'h0,    1'b0, 4'd6}, // R8 load no R
    '{1'b1, 1'b0, 32'h00403456, 2'd1, 22'h403,  1'b1, 4'd3}, // R9 superpage
    '{1'b0, 1'b0, 32'h00800000, 2'd2, 22'h0,    1'b0, 4'd3}, // R6 misaligned
    '{1'b1, 1'b0, 32'h00C00000, 2'd3, 22'h0,    1'b0, 4'd3}, // R5 V=0
    '{1'b1, 1'b1, 32'h01000000, 2'd3, 22'h0,    1'b0, 4'd3}, // R5 W without R
    '{1'b1, 1'b1, 32'h01405000, 2'd3, 22'h0,    1'b0, 4'd4}, // R8 store read-only super
    '{1'b1, 1'b0, 32'h01405000, 2'd1, 22'h1405, 1'b1, 4'd3}, // R9 read-only super
    '{1'b1, 1'b0, 32'h00003000, 2'd3, 22'h0,    1'b0, 4'd5}, // R7 pointer at L0
    '{1'b0, 1'b0, 32'h00004000, 2'd2, 22'h0,    1'b0, 4'd5}  // R5 V=0 at L0
  };

  task automatic wait_result(output int lat, output logic [1:0] kind);
    lat = 0;
    kind = 2'd0;
    do begin
      step();
      lat++;
    end while (!(ifill | dfill | ifault | dfault) && lat < 30);
    kind = dfill ? 2'd1 : ifault ? 2'd2 : dfault ? 2'd3 : 2'd0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [1:0] kind;
    // page tables: root at 0x5000, level-0 table at 0x6000
    pmem[34'h5000] = 32'h00001801; // pointer -> ppn 6
    pmem[34'h5004] = 32'h001000CF; // super ppn1=1 RWX
    pmem[34'h5008] = 32'h00200CCF; // super, ppn0 != 0
    pmem[34'h5010] = 32'h00000005; // V W, no R
    pmem[34'h5014] = 32'h00500043; // super ppn1=5 read only
    pmem[34'h6004] = 32'h00048CC7; // 4K ppn 0x123 RW
    pmem[34'h6008] = 32'h0001DC49; // 4K ppn 0x77 X only
    pmem[34'h600C] = 32'h00001801; // pointer at level 0

    repeat (3) @(negedge clk);
    chk("R1 active in reset", active, 0);
    rst_n = 1'b1;
    step();
    chk("R1 active", active, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 strobes", {ifill, dfill, ifault, dfault}, 0);

    // R2: disabled paging ignores a held miss
    dmiss = 1'b1; dva = 32'h00001000;
    repeat (4) step();
    chk("R2 active while disabled", active, 0);
    chk("R2 mem_req while disabled", mem_req, 0);
    dmiss = 1'b0;
    paging_en = 1'b1;
    step();

    foreach (VECS[i]) begin
      if (VECS[i].d) begin dmiss = 1'b1; dva = VECS[i].va; dstore = VECS[i].st; end
      else begin imiss = 1'b1; iva = VECS[i].va; end
      wait_result(lat, kind);
      dmiss = 1'b0; imiss = 1'b0;
      chk($sformatf("R10 kind vec %0d", i), kind, VECS[i].kind);
      chk($sformatf("R11 latency vec %0d", i), lat, VECS[i].lat);
      if (!kind[1]) begin
        chk($sformatf("R9 ppn vec %0d", i), fppn, VECS[i].ppn);
        chk($sformatf("R9 super vec %0d", i), fsuper, VECS[i].sup);
        chk($sformatf("R9 vpn vec %0d", i), fvpn, VECS[i].va[31:12]);
      end
      step();
      chk($sformatf("R10 idle after vec %0d", i), active, 0);
    end

    // R3 R4 R13: request addresses, one outstanding
    dmiss = 1'b1; dva = 32'h00001ABC; dstore = 1'b0;
    step();
    chk("R11 active after start", active, 1);
    chk("R3 l1 req", mem_req, 1);
    chk("R3 l1 addr", mem_addr, 34'h5000);
    step();
    chk("R13 no req while waiting", mem_req, 0);
    step();
    chk("R4 l0 req", mem_req, 1);
    chk("R4 l0 addr", mem_addr, 34'h6004);
    wait_result(lat, kind);
    dmiss = 1'b0;
    chk("R4 fill ppn", fppn, 22'h123);
    step();

    // R13: grant withheld, request held
    gnt_en = 1'b0;
    dmiss = 1'b1; dva = 32'h00403456;
    step();
    step();
    step();
    chk("R13 req held", mem_req, 1);
    chk("R13 addr held", mem_addr, 34'h5004);
    gnt_en = 1'b1;
    wait_result(lat, kind);
    dmiss = 1'b0;
    chk("R13 fill after stall", kind, 2'd1);
    chk("R13 stall latency", lat, 2);
    chk("R13 ppn after stall", fppn, 22'h403);
    step();

    // R12: simultaneous misses, data side first
    imiss = 1'b1; iva = 32'h00002000;
    dmiss = 1'b1; dva = 32'h00001ABC; dstore = 1'b0;
    wait_result(lat, kind);
    dmiss = 1'b0;
    chk("R12 data first", kind, 2'd1);
    chk("R12 data ppn", fppn, 22'h123);
    wait_result(lat, kind);
    imiss = 1'b0;
    chk("R12 inst after", kind, 2'd0);
    chk("R12 inst ppn", fppn, 22'h77);
    chk("R12 inst latency", lat, 6);
    step();
    chk("R10 idle at end", active, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule